// File: doc/BRIEF.md
# Endian-Selectable Byte Lane Packer

This block moves data between an 8-bit byte stream and a 32-bit word made of four byte lanes. One static order input picks how bytes map onto lanes. In the packing direction, incoming bytes are collected into a word. In the unpacking direction, a stored word is sent out one byte at a time. When the order input is low, the lane order runs from the lowest lane up. When it is high, the order runs from the highest lane down. Both directions use valid/ready handshakes and handle aligned, whole-word transfers only.

The same lane mapping also serves a byte-addressed external memory port, in both directions. A read from memory turns four offset-ordered bytes into a lane-ordered word. A write turns a lane-ordered word into four offset-ordered bytes. This path is purely combinational and follows the order input directly. On the streaming paths, the order input is captured once per word, so changing it while a word is partly transferred does not tear that word.

Top module: `lane_packer`

## Requirements
- R1: With the order input low when a word starts, the packer puts its first accepted byte on lane 0 (bits 7:0 of `packWord`) and each later byte on the next higher lane.
- R2: With the order input high when a word starts, the packer puts its first accepted byte on lane 3 (bits 31:24 of `packWord`) and each later byte on the next lower lane.
- R3: `packValid` rises in the cycle after the fourth byte of a word is accepted. It stays high, with `packWord` unchanged, until `packReady` is seen. While it is high, `byteInReady` is low.
- R4: The order input is sampled at the start of each word, in both directions. A change during a partly filled or partly drained word applies only from the next word.
- R5: With the order input low when a word is loaded, the unpacker emits lane 0 first and the remaining lanes in ascending order.
- R6: With the order input high when a word is loaded, the unpacker emits lane 3 first and the remaining lanes in descending order.
- R7: `byteOut` holds its value while `byteOutValid` is high and `byteOutReady` is low. `wordInReady` stays low until all four bytes of the loaded word have been taken, and is high in the cycle after the last one.
- R8: On a memory read, `memRdBytes` holds the byte at offset k in bits 8k+7:8k. With the order input low, offset k goes to lane k of `memRdWord`. With it high, offset k goes to lane 3-k.
- R9: On a memory write, `memWrBytes` carries offset k in bits 8k+7:8k. With the order input low, lane k of `memWrWord` goes to offset k. With it high, lane 3-k goes to offset k, so lane 3 lands at offset 0.
- R10: A synchronous reset clears `packValid` and `byteOutValid`, raises `byteInReady` and `wordInReady`, and drops any partly packed bytes. The next word therefore starts from its first lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bigOrder | input | 1 | Lane order select: 0 = ascending from lane 0, 1 = descending from lane 3 |
| byteIn | input | 8 | Incoming stream byte |
| byteInValid | input | 1 | byteIn is valid |
| byteInReady | output | 1 | Packer can take a byte |
| packWord | output | 32 | Packed word, lane k at bits 8k+7:8k |
| packValid | output | 1 | packWord complete and waiting |
| packReady | input | 1 | Consumer takes packWord |
| wordIn | input | 32 | Word to unpack, lane k at bits 8k+7:8k |
| wordInValid | input | 1 | wordIn is valid |
| wordInReady | output | 1 | Unpacker can load a word |
| byteOut | output | 8 | Outgoing stream byte |
| byteOutValid | output | 1 | byteOut is valid |
| byteOutReady | input | 1 | Consumer takes byteOut |
| memRdBytes | input | 32 | Bytes read from memory, offset k at bits 8k+7:8k |
| memRdWord | output | 32 | Read data mapped onto lanes |
| memWrWord | input | 32 | Word to write to memory, lane k at bits 8k+7:8k |
| memWrBytes | output | 32 | Write data mapped onto offsets |

## Verification
The hardest case to reach is a change of the order input in the middle of a word. It has to happen after the first byte has been accepted but before the last one, and the word must be checked against the order that was in force at its start. The driver tasks flip the select right after the first byte handshake (packing) or right after the word load (unpacking). The next word is then sent with the new order, so both the held value and the switch-over are scored. Back-pressure phases drop the ready inputs in a repeating pattern so that held words and held bytes are checked for stability, and a reset issued halfway through a word checks that the leftover bytes are discarded.

// File: rtl/lane_packer_pkg.sv
package lane_packer_pkg;
  localparam int LANE_CNT = 4;
  localparam int LANE_IDX_W = $clog2(LANE_CNT);

  typedef logic [LANE_IDX_W-1:0] lane_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  packWrite;
    lane_t packLane;
    logic  unpackLoad;
    lane_t unpackLane;
  } strobes_t;

  // byte position within a word -> lane index for the given order
  function automatic lane_t mapLane(input lane_t pos, input logic big);
    return big ? (lane_t'(LANE_CNT - 1) - pos) : pos;
  endfunction
endpackage

// File: rtl/lane_packer_ctrl.sv
module lane_packer_ctrl
  import lane_packer_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bigOrder,
  input  logic     byteInValid,
  output logic     byteInReady,
  output logic     packValid,
  input  logic     packReady,
  input  logic     wordInValid,
  output logic     wordInReady,
  output logic     byteOutValid,
  input  logic     byteOutReady,
  output strobes_t strobes
);
  localparam lane_t LAST = lane_t'(LANE_CNT - 1);

  lane_t packCnt;
  lane_t txCnt;
  logic  packBigQ;
  logic  txBigQ;
  logic  packFull;
  logic  txBusy;
  logic  packSel;
  logic  packAcc;
  logic  loadAcc;
  logic  txAdv;

  // order taken live on the first byte, then held for the rest of the word
  assign packSel     = (packCnt == '0) ? bigOrder : packBigQ;
  assign byteInReady = !packFull;
  assign packAcc     = byteInValid && byteInReady;
  assign packValid   = packFull;

  assign wordInReady  = !txBusy;
  assign loadAcc      = wordInValid && wordInReady;
  assign txAdv        = txBusy && byteOutReady;
  assign byteOutValid = txBusy;

  always_ff @(posedge clk) begin
    if (rst) begin
      packCnt  <= '0;
      packBigQ <= 1'b0;
      packFull <= 1'b0;
    end else begin
      if (packFull && packReady) packFull <= 1'b0;
      if (packAcc) begin
        if (packCnt == '0) packBigQ <= bigOrder;
        packCnt <= packCnt + 1'b1;
        if (packCnt == LAST) packFull <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txCnt  <= '0;
      txBigQ <= 1'b0;
      txBusy <= 1'b0;
    end else if (loadAcc) begin
      txBusy <= 1'b1;
      txCnt  <= '0;
      txBigQ <= bigOrder;
    end else if (txAdv) begin
      txCnt <= txCnt + 1'b1;
      if (txCnt == LAST) txBusy <= 1'b0;
    end
  end

  always_comb begin
    strobes.packWrite  = packAcc;
    strobes.packLane   = mapLane(packCnt, packSel);
    strobes.unpackLoad = loadAcc;
    strobes.unpackLane = mapLane(txCnt, txBigQ);
  end

  assert_word_after_fourth_R3: assert property (@(posedge clk) disable iff (rst)
    (packAcc && packCnt == LAST) |=> packValid);
  assert_word_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (packValid && !packReady) |=> (packValid && !byteInReady));
  assert_busy_until_drained_R7: assert property (@(posedge clk) disable iff (rst)
    (byteOutValid && !(byteOutReady && txCnt == LAST)) |=> (byteOutValid && !wordInReady));
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!packValid && !byteOutValid && byteInReady && wordInReady));
endmodule

// File: rtl/lane_packer_dp.sv
module lane_packer_dp
  import lane_packer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W * LANE_CNT
) (
  input  logic              clk,
  input  logic              bigOrder,
  input  strobes_t          strobes,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [WORD_W-1:0] wordIn,
  output logic [WORD_W-1:0] packWord,
  output logic [BYTE_W-1:0] byteOut,
  input  logic [WORD_W-1:0] memRdBytes,
  output logic [WORD_W-1:0] memRdWord,
  input  logic [WORD_W-1:0] memWrWord,
  output logic [WORD_W-1:0] memWrBytes
);
  logic [LANE_CNT-1:0][BYTE_W-1:0] packReg;
  logic [LANE_CNT-1:0][BYTE_W-1:0] txReg;

  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (strobes.packWrite && strobes.packLane == lane_t'(g)) packReg[g] <= byteIn;
    end
    // the lane reversal is its own inverse, so reads and writes share one form
    assign memRdWord[g*BYTE_W +: BYTE_W] = bigOrder
      ? memRdBytes[(LANE_CNT-1-g)*BYTE_W +: BYTE_W] : memRdBytes[g*BYTE_W +: BYTE_W];
    assign memWrBytes[g*BYTE_W +: BYTE_W] = bigOrder
      ? memWrWord[(LANE_CNT-1-g)*BYTE_W +: BYTE_W] : memWrWord[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (strobes.unpackLoad) txReg <= wordIn;
  end

  assign packWord = packReg;
  assign byteOut  = txReg[strobes.unpackLane];
endmodule

// File: rtl/lane_packer.sv
module lane_packer
  import lane_packer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W * LANE_CNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bigOrder,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              byteInValid,
  output logic              byteInReady,
  output logic [WORD_W-1:0] packWord,
  output logic              packValid,
  input  logic              packReady,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordInValid,
  output logic              wordInReady,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteOutValid,
  input  logic              byteOutReady,
  input  logic [WORD_W-1:0] memRdBytes,
  output logic [WORD_W-1:0] memRdWord,
  input  logic [WORD_W-1:0] memWrWord,
  output logic [WORD_W-1:0] memWrBytes
);
  strobes_t strobes;

  lane_packer_ctrl uCtrl (
    .clk          (clk),
    .rst          (rst),
    .bigOrder     (bigOrder),
    .byteInValid  (byteInValid),
    .byteInReady  (byteInReady),
    .packValid    (packValid),
    .packReady    (packReady),
    .wordInValid  (wordInValid),
    .wordInReady  (wordInReady),
    .byteOutValid (byteOutValid),
    .byteOutReady (byteOutReady),
    .strobes      (strobes)
  );

  lane_packer_dp #(.BYTE_W(BYTE_W)) uDp (
    .clk        (clk),
    .bigOrder   (bigOrder),
    .strobes    (strobes),
    .byteIn     (byteIn),
    .wordIn     (wordIn),
    .packWord   (packWord),
    .byteOut    (byteOut),
    .memRdBytes (memRdBytes),
    .memRdWord  (memRdWord),
    .memWrWord  (memWrWord),
    .memWrBytes (memWrBytes)
  );

  assert_word_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (packValid && !packReady) |=> $stable(packWord));
  assert_byte_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (byteOutValid && !byteOutReady) |=> $stable(byteOut));
endmodule

// File: tb/lane_packer_test.sv
module lane_packer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bigOrder = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        byteInValid = 1'b0;
  logic        byteInReady;
  logic [31:0] packWord;
  logic        packValid;
  logic        packReady = 1'b1;
  logic [31:0] wordIn = '0;
  logic        wordInValid = 1'b0;
  logic        wordInReady;
  logic [7:0]  byteOut;
  logic        byteOutValid;
  logic        byteOutReady = 1'b1;
  logic [31:0] memRdBytes = '0;
  logic [31:0] memRdWord;
  logic [31:0] memWrWord = '0;
  logic [31:0] memWrBytes;

  int checks = 0;
  int fails = 0;
  logic [31:0] wordQ[$];
  logic [7:0]  byteQ[$];
  bit stallMode = 1'b0;
  int bpCnt = 0;

  lane_packer uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // back-pressure pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    bpCnt++;
    packReady    = stallMode ? (bpCnt % 3 == 0) : 1'b1;
    byteOutReady = stallMode ? (bpCnt % 4 != 1) : 1'b1;
  end

  // monitor: sample mid-cycle, score handshakes that complete at the next edge
  logic        holdW = 1'b0, holdB = 1'b0;
  logic [31:0] prevW;
  logic [7:0]  prevB;
  always @(negedge clk) begin
    if (rst) begin
      holdW = 1'b0;
      holdB = 1'b0;
    end else begin
      if (packValid) check(!byteInReady, "R3 input stalled while word held", 32'(byteInReady), 32'h0);
      if (holdW) check(packValid && packWord === prevW, "R3 held word stable", packWord, prevW);
      holdW = packValid && !packReady;
      prevW = packWord;
      if (packValid && packReady) begin
        if (wordQ.size() == 0) check(1'b0, "R1 R2 unexpected word", packWord, 32'h0);
        else begin
          logic [31:0] e;
          e = wordQ.pop_front();
          check(packWord === e, "R1 R2 R4 R10 packed word", packWord, e);
        end
      end
      if (holdB) check(byteOutValid && byteOut === prevB, "R7 held byte stable", 32'(byteOut), 32'(prevB));
      holdB = byteOutValid && !byteOutReady;
      prevB = byteOut;
      if (byteOutValid && byteOutReady) begin
        if (byteQ.size() == 0) check(1'b0, "R5 R6 unexpected byte", 32'(byteOut), 32'h0);
        else begin
          logic [7:0] e;
          e = byteQ.pop_front();
          check(byteOut === e, "R5 R6 R4 emitted byte", 32'(byteOut), 32'(e));
        end
      end
    end
  end

  // all driver tasks start just after a rising edge
  task automatic sendByte(input logic [7:0] b);
    byteInValid = 1'b1;
    byteIn = b;
    do @(negedge clk); while (!byteInReady);
    @(posedge clk); #2;
    byteInValid = 1'b0;
  endtask

  task automatic packWordTask(input logic [31:0] bytes, input bit sel, input bit flip);
    logic [31:0] e;
    for (int i = 0; i < 4; i++) begin
      int lane;
      lane = sel ? 3 - i : i;
      e[lane*8 +: 8] = bytes[i*8 +: 8];
    end
    wordQ.push_back(e);
    bigOrder = sel;
    for (int i = 0; i < 4; i++) begin
      sendByte(bytes[i*8 +: 8]);
      if (i == 0 && flip) bigOrder = !sel;
    end
  endtask

  task automatic sendWord(input logic [31:0] w, input bit sel, input bit flip);
    for (int i = 0; i < 4; i++) begin
      int lane;
      lane = sel ? 3 - i : i;
      byteQ.push_back(w[lane*8 +: 8]);
    end
    bigOrder = sel;
    wordIn = w;
    wordInValid = 1'b1;
    do @(negedge clk); while (!wordInReady);
    @(posedge clk); #2;
    wordInValid = 1'b0;
    if (flip) bigOrder = !sel;
    @(negedge clk);
    check(!wordInReady && byteOutValid, "R7 loader blocked while draining", 32'(wordInReady), 32'h0);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 R5 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(!packValid && !byteOutValid && byteInReady && wordInReady, "R10 reset state",
          {packValid, byteOutValid, byteInReady, wordInReady}, 32'h3);

    // external memory mapping, offset k at bits 8k+7:8k
    memRdBytes = 32'h44332211;
    memWrWord  = 32'hA0B0C0D0;
    bigOrder = 1'b0; #1;
    check(memRdWord === 32'h44332211, "R8 read ascending", memRdWord, 32'h44332211);
    check(memWrBytes === 32'hA0B0C0D0, "R9 write ascending", memWrBytes, 32'hA0B0C0D0);
    bigOrder = 1'b1; #1;
    check(memRdWord === 32'h11223344, "R8 read descending", memRdWord, 32'h11223344);
    check(memWrBytes === 32'hD0C0B0A0, "R9 write descending", memWrBytes, 32'hD0C0B0A0);
    memRdBytes = 32'h0F00FF5A; #1;
    check(memRdWord === 32'h5AFF000F, "R8 read pattern", memRdWord, 32'h5AFF000F);

    @(posedge clk); #2;
    // packing: R1 ascending, R2 descending
    packWordTask(32'h04030201, 1'b0, 1'b0);
    packWordTask(32'h14131211, 1'b1, 1'b0);
    packWordTask(32'hDDCCBBAA, 1'b0, 1'b0);
    stallMode = 1'b1;
    packWordTask(32'h89ABCDEF, 1'b1, 1'b0);
    packWordTask(32'h01234567, 1'b0, 1'b0);
    // R4: flip after first byte, next word follows the new order
    packWordTask(32'h55667788, 1'b0, 1'b1);
    packWordTask(32'h99AABBCC, 1'b1, 1'b1);
    packWordTask(32'h31415926, 1'b0, 1'b0);
    stallMode = 1'b0;
    while (wordQ.size() != 0) @(posedge clk);
    #2;

    // R10: reset with a half-filled word
    bigOrder = 1'b0;
    sendByte(8'hE1);
    sendByte(8'hE2);
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    @(negedge clk);
    check(byteInReady && !packValid, "R10 mid-word reset", {byteInReady, packValid}, 32'h2);
    @(posedge clk); #2;
    packWordTask(32'hC4C3C2C1, 1'b0, 1'b0);
    packWordTask(32'hB4B3B2B1, 1'b1, 1'b0);
    while (wordQ.size() != 0) @(posedge clk);
    #2;

    // unpacking: R5 ascending, R6 descending
    sendWord(32'h44332211, 1'b0, 1'b0);
    sendWord(32'h88776655, 1'b1, 1'b0);
    stallMode = 1'b1;
    sendWord(32'hCAFEF00D, 1'b0, 1'b0);
    sendWord(32'hDEADBEEF, 1'b1, 1'b0);
    // R4 on the unpacking side
    sendWord(32'h13579BDF, 1'b0, 1'b1);
    sendWord(32'h2468ACE0, 1'b1, 1'b1);
    sendWord(32'h0A0B0C0D, 1'b0, 1'b0);
    while (byteQ.size() != 0) @(posedge clk);
    stallMode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wordInReady && !byteOutValid, "R7 loader free after drain", {wordInReady, byteOutValid}, 32'h2);
    check(wordQ.size() == 0 && byteQ.size() == 0, "R1 R5 queues drained", wordQ.size() + byteQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule